// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a local countdown timer that raises an interrupt. Software programs a start count, a clock divider and an interrupt entry through a small word-addressed register bus. Writing the start count loads the counter and restarts the divider. The counter then steps down once per divided clock. When it passes from one to zero the timer expires.

On expiry the timer either stops at zero (one-shot) or reloads the start count and runs again (periodic). It raises an interrupt request that carries the 8-bit vector from the interrupt entry, unless that entry is masked. The request stays high until the consumer pulses the acknowledge input. A masked timer keeps counting and reloading but never raises the request.

Top module: `tmr_local_timer`

## Requirements
- R1: After reset, irq_req is 0, the counter and start count read 0, the divide register reads 0, and the interrupt entry reads 0x0001_0000 (masked, one-shot, vector 0).
- R2: Registers sit at word addresses 0xC8 (interrupt entry), 0xE0 (start count), 0xE4 (current count) and 0xF8 (divide). Read data appears on bus_rdata on the edge that samples bus_rd. Any other address reads 0.
- R3: A write to the start count loads the counter and clears the divider. With divide ratio D and a start count N, the interrupt request rises exactly N*D clock edges after the write edge. A later write restarts the count from the new value.
- R4: Divide register bits [3:0]: 0xB gives /1, 0x0 /2, 0x1 /4, 0x2 /8, 0x3 /16, 0x8 /32, 0x9 /64, 0xA /128. Bit 2 and bits above 3 are not stored and read back as 0.
- R5: When bit 17 of the interrupt entry is 0 (one-shot), the counter stays at 0 after expiry and no further request occurs.
- R6: When bit 17 of the interrupt entry is 1 (periodic), the counter reloads the start count on expiry and expires again every N*D edges.
- R7: When bit 16 of the interrupt entry is 1 (masked), expiry raises no request, but the counter still counts down and reloads.
- R8: On an unmasked expiry, irq_vec takes bits [7:0] of the interrupt entry and holds them while the request is pending.
- R9: irq_req stays high until an edge with irq_ack high clears it. An expiry on that same edge keeps it set.
- R10: Writing 0 to the start count stops the timer: the counter reads 0 and no request is raised.
- R11: Writes to the current-count address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer's count clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Pending interrupt request |
| irq_vec | output | 8 | Vector of the pending request |
| irq_ack | input | 1 | Acknowledge; clears the request |

## Verification
The hardest case to reach is an acknowledge that arrives on the very edge on which a periodic timer expires again. The ack must lose to the new expiry, and that edge is fixed only by the exact cycle arithmetic of N*D. The stimulus writes a short periodic count at divide-by-1. It counts edges from the write edge and drives the acknowledge so that it is sampled on the second expiry edge. It then checks that the request stays up, and that a later plain acknowledge clears it. Each divide encoding is timed to the exact edge from the write, so a ratio that is off by one shows up as a request that is early or late.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int VEC_W = 8;

  // Word addresses (byte offset / 4)
  localparam int WA_ENTRY = 'hC8;
  localparam int WA_START = 'hE0;
  localparam int WA_CUR   = 'hE4;
  localparam int WA_DIV   = 'hF8;

  // Bit positions inside the interrupt entry word
  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_PER_BIT  = 17;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // Packs divide bits {3,1,0} into a 3-bit code; code+1 (mod 8) is the shift.
  function automatic logic [2:0] div_code(input logic [3:0] enc);
    return {enc[3], enc[1:0]};
  endfunction
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_cnt,
  output logic [DATA_W-1:0] rdata,
  output entry_t            entry,
  output logic [3:0]        div_enc,
  output logic [DATA_W-1:0] start_cnt,
  output logic              load
);
  localparam logic [ADDR_W-1:0] A_ENTRY = ADDR_W'(WA_ENTRY);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(WA_START);
  localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(WA_CUR);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(WA_DIV);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DATA_W-1:ENTRY_PER_BIT+1],
                          wdata[ENTRY_MASK_BIT-1:VEC_W], wdata[2]};

  assign load = wr && (addr == A_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry     <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
      div_enc   <= 4'h0;
      start_cnt <= '0;
    end else if (wr) begin
      case (addr)
        A_ENTRY: begin
          entry.vec      <= wdata[VEC_W-1:0];
          entry.mask     <= wdata[ENTRY_MASK_BIT];
          entry.periodic <= wdata[ENTRY_PER_BIT];
        end
        A_START: start_cnt <= wdata;
        A_DIV:   div_enc   <= {wdata[3], 1'b0, wdata[1:0]};
        default: ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_ENTRY: begin
        rd_mux[VEC_W-1:0]     = entry.vec;
        rd_mux[ENTRY_MASK_BIT] = entry.mask;
        rd_mux[ENTRY_PER_BIT]  = entry.periodic;
      end
      A_START: rd_mux = start_cnt;
      A_CUR:   rd_mux = cur_cnt;
      A_DIV:   rd_mux[3:0] = div_enc;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int MAX_SHIFT = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [3:0] div_enc,
  output logic       tick
);
  localparam int PRE_W = MAX_SHIFT;

  logic [2:0]       shift;
  logic [PRE_W:0]   pow2;
  logic [PRE_W-1:0] limit;
  logic [PRE_W-1:0] pre;

  always_comb begin
    shift = div_code(div_enc) + 3'd1;
    pow2  = (PRE_W+1)'(1) << shift;
    limit = PRE_W'(pow2 - 1'b1);
  end

  assign tick = (pre == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) pre <= '0;
    else if (tick)      pre <= '0;
    else                pre <= pre + 1'b1;
  end
endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = !load && tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      if (cnt == ONE) cnt <= periodic ? reload_val : '0;
      else            cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  entry_t           entry,
  input  logic             ack,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= '0;
    end else if (expire && !entry.mask) begin
      req <= 1'b1;
      vec <= entry.vec;
    end else if (ack) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_local_timer.sv
module tmr_local_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int MAX_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  entry_t            entry_w;
  logic [3:0]        div_w;
  logic [DATA_W-1:0] start_cnt_w;
  logic [DATA_W-1:0] cur_cnt_w;
  logic              load_w;
  logic              tick_w;
  logic              expire_w;
  logic              lvt_mask_w;
  logic              lvt_periodic_w;

  assign lvt_mask_w     = entry_w.mask;
  assign lvt_periodic_w = entry_w.periodic;

  tmr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cur_cnt(cur_cnt_w), .rdata(bus_rdata),
    .entry(entry_w), .div_enc(div_w), .start_cnt(start_cnt_w), .load(load_w)
  );

  tmr_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .restart(load_w), .div_enc(div_w), .tick(tick_w)
  );

  tmr_downcounter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_w), .load_val(bus_wdata),
    .reload_val(start_cnt_w), .periodic(entry_w.periodic), .tick(tick_w),
    .cnt(cur_cnt_w), .expire(expire_w)
  );

  tmr_irq_out u_irq (
    .clk(clk), .rst(rst), .expire(expire_w), .entry(entry_w),
    .ack(irq_ack), .req(irq_req), .vec(irq_vec)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vec,
  input logic             expire,
  input logic             lvt_mask,
  input logic             lvt_periodic,
  input logic             load,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [CNT_W-1:0] start_cnt
);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    irq_ack && !expire |=> !irq_req);

  assert_rise_needs_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(expire && !lvt_mask));

  assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (rst)
    expire && !lvt_periodic |=> cur_cnt == '0);

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (rst)
    expire && lvt_periodic |=> cur_cnt == $past(start_cnt));

  assert_vec_stable_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack && !expire |=> $stable(irq_vec));

  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> cur_cnt == start_cnt);

  assert_zero_stays_R10: assert property (@(posedge clk) disable iff (rst)
    cur_cnt == '0 && !load |=> cur_cnt == '0);
endmodule

bind tmr_local_timer tmr_checker #(.CNT_W(DATA_W), .VEC_W(tmr_pkg::VEC_W)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
  .expire(expire_w), .lvt_mask(lvt_mask_w), .lvt_periodic(lvt_periodic_w),
  .load(load_w), .cur_cnt(cur_cnt_w), .start_cnt(start_cnt_w)
);

// File: tb/sim_tmr_local_timer.sv
`timescale 1ns/1ps
module sim_tmr_local_timer;
  localparam logic [7:0] A_ENTRY = 8'hC8;
  localparam logic [7:0] A_START = 8'hE0;
  localparam logic [7:0] A_CUR   = 8'hE4;
  localparam logic [7:0] A_DIV   = 8'hF8;
  localparam logic [31:0] PER  = 32'h0002_0000;
  localparam logic [31:0] MSK  = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  tmr_local_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(posedge clk); @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_expiry(input int k, input string req);
    repeat (k - 1) @(posedge clk);
    @(negedge clk);
    chk(irq_req == 1'b0, req, {31'b0, irq_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk(irq_req == 1'b1, req, {31'b0, irq_req}, 32'd1);
  endtask

  task automatic quiesce();
    bus_write(A_START, 32'd0);
    ack_pulse();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(irq_req == 1'b0, "R1 irq", {31'b0, irq_req}, 32'd0);
    bus_read(A_ENTRY, d); chk(d == MSK, "R1 entry", d, MSK);
    bus_read(A_DIV, d);   chk(d == 0, "R1 divide", d, 0);
    bus_read(A_START, d); chk(d == 0, "R1 start", d, 0);
    bus_read(A_CUR, d);   chk(d == 0, "R1 current", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    bus_write(A_ENTRY, 32'hFFFF_FF7E);
    bus_read(A_ENTRY, d); chk(d == 32'h0003_007E, "R2 entry map", d, 32'h0003_007E);
    bus_read(8'h00, d);   chk(d == 0, "R2 unmapped", d, 0);
    bus_write(A_DIV, 32'hFFFF_FFFF);
    bus_read(A_DIV, d);   chk(d == 32'hB, "R4 div bits", d, 32'hB);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    quiesce();
    bus_write(A_DIV, 32'hB);
    bus_write(A_ENTRY, 32'h41);
    bus_write(A_START, 32'd5);
    wait_expiry(5, "R3 one-shot timing");
    chk(irq_vec == 8'h41, "R8 vector", {24'b0, irq_vec}, 32'h41);
    ack_pulse();
    chk(irq_req == 1'b0, "R9 ack clears", {31'b0, irq_req}, 0);
    bus_read(A_CUR, d); chk(d == 0, "R5 current zero", d, 0);
    idle(20);
    chk(irq_req == 1'b0, "R5 no repeat", {31'b0, irq_req}, 0);
  endtask

  task automatic t_divides();
    int encs [8] = '{'hB, 0, 1, 2, 3, 8, 9, 'hA};
    int divs [8] = '{1, 2, 4, 8, 16, 32, 64, 128};
    for (int i = 0; i < 8; i++) begin
      quiesce();
      bus_write(A_DIV, encs[i]);
      bus_write(A_ENTRY, 32'h30);
      bus_write(A_START, 32'd3);
      wait_expiry(3 * divs[i], $sformatf("R4 divide enc 0x%0h", encs[i]));
    end
    ack_pulse();
  endtask

  task automatic t_periodic_collide();
    quiesce();
    bus_write(A_DIV, 32'hB);
    bus_write(A_ENTRY, PER | 32'h5A);
    bus_write(A_START, 32'd4);
    idle(4);
    chk(irq_req == 1'b1, "R6 first expiry", {31'b0, irq_req}, 1);
    chk(irq_vec == 8'h5A, "R8 vector periodic", {24'b0, irq_vec}, 32'h5A);
    idle(3);
    ack_pulse();
    chk(irq_req == 1'b1, "R9 ack loses to expiry", {31'b0, irq_req}, 1);
    ack_pulse();
    chk(irq_req == 1'b0, "R9 ack clears", {31'b0, irq_req}, 0);
    wait_expiry(3, "R6 period");
  endtask

  task automatic t_masked();
    logic [31:0] d;
    quiesce();
    bus_write(A_DIV, 32'hB);
    bus_write(A_ENTRY, PER | MSK | 32'h11);
    bus_write(A_START, 32'd10);
    idle(25);
    chk(irq_req == 1'b0, "R7 masked no irq", {31'b0, irq_req}, 0);
    bus_read(A_CUR, d);
    chk(d >= 1 && d <= 10, "R7 masked keeps reloading", d, 32'd10);
  endtask

  task automatic t_stop_restart();
    logic [31:0] d;
    quiesce();
    bus_write(A_DIV, 32'hB);
    bus_write(A_ENTRY, 32'h22);
    bus_write(A_START, 32'd8);
    idle(3);
    bus_write(A_START, 32'd0);
    idle(20);
    chk(irq_req == 1'b0, "R10 stop no irq", {31'b0, irq_req}, 0);
    bus_read(A_CUR, d); chk(d == 0, "R10 stop current", d, 0);
    bus_write(A_ENTRY, PER | 32'h22);
    bus_write(A_START, 32'd50);
    idle(10);
    bus_write(A_START, 32'd3);
    wait_expiry(3, "R3 restart");
    ack_pulse();
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    quiesce();
    bus_write(A_ENTRY, MSK);
    bus_write(A_START, 32'd2);
    idle(5);
    bus_write(A_CUR, 32'h55);
    bus_read(A_CUR, d); chk(d == 0, "R11 current read-only", d, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map();
    t_oneshot();
    t_divides();
    t_periodic_collide();
    t_masked();
    t_stop_restart();
    t_readonly();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule